// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Register

This block sits between a USB function controller's protocol engine and the CPU. Single-cycle event pulses from the engine set sticky flags for the control endpoint (endpoint 0). The events are: a setup packet that needs decoding, OUT data received, an IN token that found no data, and IN data acknowledged by the host. A fifth, read-only bit shows live whether the double-buffered bulk IN endpoint (endpoint 2) has a free buffer. Software clears a sticky flag by writing 0 to its bit. A separate enable register masks the five bits, and the result is ORed into one interrupt line.

The block also keeps the endpoint 0 IN "data ready" state. Software sets it through a control register once a packet is loaded. The engine reads `ep0_in_nack_o` to decide whether to answer an IN token with NACK or with data. The host ACK of the transmitted packet clears the state again.

All registers sit on a simple synchronous bus with address, write enable and 8-bit data. Reads are combinational.

Top module: `usb_ep_irq_flags`

## Requirements
- R1: After reset, the flag register (address 0) reads 0x10 while at least one endpoint 2 buffer is free. The enable register (address 1) reads 0x00. The control register (address 2) reads 0x00, and `ep0_in_nack_o` is 1.
- R2: Flag bit 4 equals the OR of `ep2_buf_free_i` at all times. Writes cannot change it, and bits 7..5 of the flag register read 0.
- R3: A `setup_evt_i` pulse sets flag bit 3, and an `ep0_out_evt_i` pulse sets flag bit 2. Each flag is visible from the cycle after the pulse.
- R4: An `ep0_in_token_i` pulse while data ready is 0 sets flag bit 1. While data ready is 0, `ep0_in_nack_o` is 1.
- R5: An `ep0_in_ack_i` pulse sets flag bit 0 and clears data ready (control bit 0).
- R6: A write to address 0 clears each of bits 3..0 whose written value is 0, and leaves unchanged each bit written with 1.
- R7: When a set event and a write-zero clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is 1 exactly when some bit of {flag bits 4..0} AND {enable bits 4..0} is 1.
- R9: Writing 1 to bit 0 of address 2 sets data ready and drives `ep0_in_nack_o` to 0. A token pulse while data ready is 1 leaves flag bit 1 unchanged.
- R10: The enable register stores written bits 4..0 and reads bits 7..5 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address (0 flags, 1 enable, 2 control) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| setup_evt_i | input | 1 | Setup packet needing decode was ACKed |
| ep0_out_evt_i | input | 1 | EP0 OUT data stored and ACKed |
| ep0_in_token_i | input | 1 | IN token for EP0 received |
| ep0_in_ack_i | input | 1 | Host ACKed EP0 IN data |
| ep2_buf_free_i | input | EP2_BUFS | Per-buffer free status of EP2 IN ping-pong buffers |
| ep0_in_nack_o | output | 1 | 1: answer EP0 IN token with NACK |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default values: two endpoint 2 buffers and a 2-bit address. With these values the full cross-product of enable masks, flag patterns and buffer states is small enough to sweep completely. It also sweeps all sixteen clear patterns and drives a set event and a clear into the same cycle for each flag.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned STAT_W    = NUM_FLAGS + 1;
  localparam int unsigned BIT_IN_DONE  = 0;
  localparam int unsigned BIT_IN_REQ   = 1;
  localparam int unsigned BIT_OUT_DONE = 2;
  localparam int unsigned BIT_SETUP    = 3;
  localparam int unsigned BIT_EP2_FREE = 4;
endpackage

// File: rtl/uei_flag_bank.sv
module uei_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uei_ep0_in_ctrl.sv
module uei_ep0_in_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ack_i,
  input  logic token_i,
  output logic ready_o,
  output logic nack_o,
  output logic req_evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ready_o <= 1'b0;
    else if (arm_i)  ready_o <= 1'b1;
    else if (ack_i)  ready_o <= 1'b0;
  end

  assign nack_o    = ~ready_o;
  assign req_evt_o = token_i & ~ready_o;
endmodule

// File: rtl/usb_ep_irq_flags.sv
module usb_ep_irq_flags
  import usb_ep_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EP2_BUFS  = 2,
  parameter int unsigned ADDR_FLAG = 0,
  parameter int unsigned ADDR_MASK = 1,
  parameter int unsigned ADDR_CTRL = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                setup_evt_i,
  input  logic                ep0_out_evt_i,
  input  logic                ep0_in_token_i,
  input  logic                ep0_in_ack_i,
  input  logic [EP2_BUFS-1:0] ep2_buf_free_i,
  output logic                ep0_in_nack_o,
  output logic                irq_o
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  logic [NUM_FLAGS-1:0] flag_q, flag_set, flag_clr;
  logic [STAT_W-1:0]    mask_q, status;
  logic                 rdy_q, in_req_evt;
  logic                 wr_flag, wr_mask, wr_ctrl;
  logic                 unused_wdata;

  assign wr_flag = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));
  assign wr_mask = wr_en_i && (addr_i == ADDR_W'(ADDR_MASK));
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign unused_wdata = ^wdata_i[DATA_W-1:STAT_W];

  uei_ep0_in_ctrl i_ep0_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (wr_ctrl & wdata_i[0]),
    .ack_i    (ep0_in_ack_i),
    .token_i  (ep0_in_token_i),
    .ready_o  (rdy_q),
    .nack_o   (ep0_in_nack_o),
    .req_evt_o(in_req_evt)
  );

  always_comb begin
    flag_set               = '0;
    flag_set[BIT_SETUP]    = setup_evt_i;
    flag_set[BIT_OUT_DONE] = ep0_out_evt_i;
    flag_set[BIT_IN_REQ]   = in_req_evt;
    flag_set[BIT_IN_DONE]  = ep0_in_ack_i;
    flag_clr = {NUM_FLAGS{wr_flag}} & ~wdata_i[NUM_FLAGS-1:0];
  end

  uei_flag_bank #(.N(NUM_FLAGS)) i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[STAT_W-1:0];
  end

  assign status = {|ep2_buf_free_i, flag_q};
  assign irq_o  = |(status & mask_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_FLAG))      rdata_o = {{PAD_W{1'b0}}, status};
    else if (addr_i == ADDR_W'(ADDR_MASK)) rdata_o = {{PAD_W{1'b0}}, mask_q};
    else if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o = {{(DATA_W-1){1'b0}}, rdy_q};
  end
endmodule

// File: rtl/usb_ep_irq_chk.sv
module usb_ep_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic       setup_evt_i,
  input logic       ep0_out_evt_i,
  input logic       ep0_in_token_i,
  input logic       ep0_in_ack_i,
  input logic [3:0] flag_q,
  input logic [4:0] mask_q,
  input logic       rdy_q,
  input logic       irq_o
);
  p_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_evt_i |=> flag_q[3]);
  p_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep0_out_evt_i |=> flag_q[2]);
  p_in_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep0_in_token_i && !rdy_q) |=> flag_q[1]);
  p_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep0_in_ack_i && !(wr_en_i && addr_i == 2'd2 && wdata_i[0])) |=> (flag_q[0] && !rdy_q));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_irq_needs_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != 5'd0));
  p_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(wr_en_i && addr_i == 2'd2 && wdata_i[0]));
endmodule

bind usb_ep_irq_flags usb_ep_irq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .setup_evt_i(setup_evt_i), .ep0_out_evt_i(ep0_out_evt_i),
  .ep0_in_token_i(ep0_in_token_i), .ep0_in_ack_i(ep0_in_ack_i),
  .flag_q(flag_q), .mask_q(mask_q), .rdy_q(rdy_q), .irq_o(irq_o)
);

// File: tb/test_usb_ep_irq_flags.sv
module test_usb_ep_irq_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       setup_evt_i = 0, ep0_out_evt_i = 0, ep0_in_token_i = 0, ep0_in_ack_i = 0;
  logic [1:0] ep2_buf_free_i = 2'b11;
  logic       ep0_in_nack_o, irq_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_ep_irq_flags i_usb_ep_irq_flags (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [3:0] f);
    @(negedge clk_i);
    {setup_evt_i, ep0_out_evt_i, ep0_in_token_i, ep0_in_ack_i} = f;
    @(negedge clk_i);
    {setup_evt_i, ep0_out_evt_i, ep0_in_token_i, ep0_in_ack_i} = '0;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd(2'd0, d); chk("R1 flags", d, 8'h10);
    rd(2'd1, d); chk("R1 mask", d, 0);
    rd(2'd2, d); chk("R1 ctrl", d, 0);
    chk("R1 nack", ep0_in_nack_o, 1);
    // R2 live buffer status, read-only
    for (int b = 0; b < 4; b++) begin
      ep2_buf_free_i = 2'(b);
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R2 ep2 bit", d, (b != 0) ? 8'h10 : 8'h00);
    end
    ep2_buf_free_i = 2'b00;
    // R3/R4/R5 individual sets
    pulse(4'b1000); rd(2'd0, d); chk("R3 setup", d, 8'h08);
    wr(2'd0, 0);
    pulse(4'b0100); rd(2'd0, d); chk("R3 out", d, 8'h04);
    wr(2'd0, 0);
    pulse(4'b0010); rd(2'd0, d); chk("R4 in req", d, 8'h02);
    chk("R4 nack", ep0_in_nack_o, 1);
    wr(2'd0, 0);
    // R9 armed: token leaves bit1 alone
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R9 ready", d, 1);
    chk("R9 nack low", ep0_in_nack_o, 0);
    pulse(4'b0010); rd(2'd0, d); chk("R9 no req", d, 8'h00);
    // R5 ack sets bit0, clears ready
    pulse(4'b0001); rd(2'd0, d); chk("R5 done", d, 8'h01);
    rd(2'd2, d); chk("R5 ready cleared", d, 0);
    chk("R5 nack back", ep0_in_nack_o, 1);
    // R6 clear sweep
    for (int v = 0; v < 16; v++) begin
      pulse(4'hF);
      wr(2'd0, 8'(v) | 8'hE0);
      rd(2'd0, d); chk("R6 clear", d, v);
    end
    // R7 set wins over clear on every flag
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 0);
      @(negedge clk_i);
      addr_i = 0; wdata_i = 0; wr_en_i = 1;
      {setup_evt_i, ep0_out_evt_i, ep0_in_token_i, ep0_in_ack_i} = 4'(1 << k);
      @(negedge clk_i);
      wr_en_i = 0;
      {setup_evt_i, ep0_out_evt_i, ep0_in_token_i, ep0_in_ack_i} = '0;
      rd(2'd0, d); chk("R7 set wins", d, 1 << k);
    end
    // R10 mask readback
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R10 mask", d, 8'h1F);
    // R8 full sweep
    for (int b = 0; b < 2; b++) begin
      ep2_buf_free_i = b ? 2'b10 : 2'b00;
      for (int f = 0; f < 16; f++) begin
        wr(2'd0, 0);
        pulse(4'(f));
        for (int m = 0; m < 32; m++) begin
          wr(2'd1, 8'(m));
          #1 chk("R8 irq", irq_o, ((((b << 4) | f) & m) != 0) ? 1 : 0);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule